// File: doc/BRIEF.md
# DS3 C-bit Overhead Frame Generator

This block sits in the transmit path of a DS3 framer. It takes a serial payload stream, one bit for each cycle in which the bit enable is high. It writes over every overhead position of the C-bit parity M-frame and sends the result out one cycle later. An M-frame is 4760 bits: seven subframes, each made of eight blocks. A block is one overhead bit followed by 84 payload bits. The block keeps its own frame position, so the caller only supplies bits.

In every subframe the overhead slots hold, in order: a leading slot, F1, the first C-bit, F2, the second C-bit, F3, the third C-bit and F4. The leading slot is an X-bit in subframes 1–2, a P-bit in subframes 3–4 and an M-bit in subframes 5–7. The X-bits carry a remote defect indication, built from four alarm inputs that each have an enable. The P-bits carry the payload parity of the previous frame. The C-bits come from side inputs or are fixed ones.

Alongside the serial output the block gives three markers: a frame-start pulse, an overhead flag, and a payload strobe. Downstream logic uses them to align to the frame.

Top module: `ds3c_framegen`

## Requirements
- R1: At a payload position, the input bit appears unchanged on `ser_out` one clock after the `bit_en` cycle that carried it.
- R2: The leading slot of subframes 5, 6 and 7 carries 0, 1 and 0 in that order.
- R3: The F slots (blocks 2, 4, 6 and 8 of each subframe) carry 1, 0, 0 and 1 in every subframe.
- R4: Both X-bits follow `rdi_mode`: 2'b01 forces 1, 2'b10 forces 0, and 2'b00 or 2'b11 selects automatic.
- R5: In automatic mode the X-bits are 0 when any alarm in `alarm_in & alarm_en` is set, and 1 otherwise. The bit order for both inputs is [0] LOS, [1] SEF, [2] LOF, [3] AIS.
- R6: Both P-bits carry the XOR of all payload bits sent in the previous M-frame. They carry 0 during the first frame after reset.
- R7: C13 is taken from `feac_bit`. C31–C33 are taken from `cpar_bit`, C41–C43 from `febe_bit`, and C51–C53 from `dlink_bit`, each sampled in the cycle of its slot.
- R8: C11, C12, C21–C23, C61–C63 and C71–C73 are sent as 1.
- R9: When `frm_en` is 0, every overhead slot except the P slots passes the payload input through. The P slots still carry parity when `par_en` is 1, and pass the payload input when `par_en` is also 0.
- R10: Each emitted bit raises exactly one of `oh_flag` and `pay_strobe` for one cycle, according to its position. `frame_start` rises with the first overhead bit of each frame, every 4760 emitted bits.
- R11: After reset all outputs are 0, and the first enabled bit is position 0 of a frame.
- R12: In a cycle with `bit_en` low, the frame position does not advance. On the next clock `ser_out` holds its value and all three markers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One serial bit is accepted this cycle |
| pay_in | input | 1 | Payload input bit |
| rdi_mode | input | 2 | X-bit source select |
| alarm_in | input | 4 | Alarm states: LOS, SEF, LOF, AIS |
| alarm_en | input | 4 | Per-alarm enable for automatic RDI |
| par_en | input | 1 | P-bit insertion enable |
| frm_en | input | 1 | Full overhead generation enable |
| feac_bit | input | 1 | FEAC bit for C13 |
| cpar_bit | input | 1 | C-bit parity bit for subframe 3 |
| febe_bit | input | 1 | FEBE bit for subframe 4 |
| dlink_bit | input | 1 | Data-link bit for subframe 5 |
| ser_out | output | 1 | Framed serial output |
| frame_start | output | 1 | Pulse with the first bit of each M-frame |
| oh_flag | output | 1 | Pulse with each overhead bit |
| pay_strobe | output | 1 | Pulse with each payload bit |

## Verification
The assertions assume that `bit_en` is a plain strobe with no other timing rule. They also assume that the framing markers come only from enabled bits. The frame-length assertion therefore counts emitted bits rather than clock cycles. The stimulus inserts idle cycles at irregular intervals inside frames, so both assumptions are tested against gaps. Configuration inputs change only at frame boundaries, so each M-frame is checked under one fixed mode. Side inputs and payload are random on every bit.

// File: rtl/ds3c_pkg.sv
package ds3c_pkg;
   // X-bit source selection
   typedef enum logic [1:0] {
      RDI_AUTO     = 2'b00,
      RDI_ONE      = 2'b01,
      RDI_ZERO     = 2'b10,
      RDI_AUTO_ALT = 2'b11
   } rdi_sel_e;

   // Number of alarm inputs feeding automatic RDI
   localparam int ALARM_N = 4;

   // Alignment patterns, first-sent bit in the MSB
   localparam logic [3:0] F_PATTERN = 4'b1001;
   localparam logic [2:0] M_PATTERN = 3'b010;
endpackage

// File: rtl/ds3c_pos_ctr.sv
module ds3c_pos_ctr #(
   parameter int SUB_N   = 7,
   parameter int BLK_N   = 8,
   parameter int BLK_LEN = 85,
   localparam int SF_W   = (SUB_N > 1) ? $clog2(SUB_N) : 1,
   localparam int BK_W   = (BLK_N > 1) ? $clog2(BLK_N) : 1,
   localparam int BT_W   = $clog2(BLK_LEN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv,
   output logic [SF_W-1:0] sf,
   output logic [BK_W-1:0] blk,
   output logic            is_oh,
   output logic            is_first,
   output logic            is_last
);
   logic [BT_W-1:0] bit_q;
   logic            bit_wrap;
   logic            blk_wrap;
   logic            sf_wrap;

   assign bit_wrap = (bit_q == BT_W'(BLK_LEN - 1));
   assign blk_wrap = (blk == BK_W'(BLK_N - 1));
   assign sf_wrap  = (sf == SF_W'(SUB_N - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_q <= '0;
         blk   <= '0;
         sf    <= '0;
      end else if (adv) begin
         if (bit_wrap) begin
            bit_q <= '0;
            if (blk_wrap) begin
               blk <= '0;
               sf  <= sf_wrap ? '0 : sf + 1'b1;
            end else begin
               blk <= blk + 1'b1;
            end
         end else begin
            bit_q <= bit_q + 1'b1;
         end
      end
   end

   assign is_oh    = (bit_q == '0);
   assign is_first = is_oh && (blk == '0) && (sf == '0);
   assign is_last  = bit_wrap && blk_wrap && sf_wrap;
endmodule

// File: rtl/ds3c_par_acc.sv
module ds3c_par_acc (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic is_pay,
   input  logic pay_bit,
   input  logic is_last,
   output logic prev_par
);
   logic acc_q;
   logic acc_nx;

   assign acc_nx = acc_q ^ (is_pay & pay_bit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q    <= 1'b0;
         prev_par <= 1'b0;
      end else if (adv) begin
         if (is_last) begin
            prev_par <= acc_nx;
            acc_q    <= 1'b0;
         end else begin
            acc_q <= acc_nx;
         end
      end
   end
endmodule

// File: rtl/ds3c_oh_sel.sv
module ds3c_oh_sel #(
   parameter int SF_W = 3,
   parameter int BK_W = 3
) (
   input  logic [SF_W-1:0] sf,
   input  logic [BK_W-1:0] blk,
   input  logic            is_oh,
   input  logic            pay_bit,
   input  logic            frm_en,
   input  logic            par_en,
   input  logic            rdi_val,
   input  logic            prev_par,
   input  logic            feac_bit,
   input  logic            cpar_bit,
   input  logic            febe_bit,
   input  logic            dlink_bit,
   output logic            out_bit
);
   import ds3c_pkg::*;

   logic       ov;
   logic       p_slot;
   logic [1:0] grp;

   assign grp = blk[2:1];

   always_comb begin
      ov     = 1'b1;
      p_slot = 1'b0;
      if (blk == '0) begin
         // leading slot: X, P or M depending on subframe
         case (sf)
            3'd0, 3'd1: ov = rdi_val;
            3'd2, 3'd3: begin
               ov     = prev_par;
               p_slot = 1'b1;
            end
            3'd4:    ov = M_PATTERN[2];
            3'd5:    ov = M_PATTERN[1];
            default: ov = M_PATTERN[0];
         endcase
      end else if (blk[0]) begin
         ov = F_PATTERN[3 - grp];
      end else begin
         // C-bit channel of this subframe
         case (sf)
            3'd0:    ov = (grp == 2'd3) ? feac_bit : 1'b1;
            3'd2:    ov = cpar_bit;
            3'd3:    ov = febe_bit;
            3'd4:    ov = dlink_bit;
            default: ov = 1'b1;
         endcase
      end
   end

   always_comb begin
      out_bit = pay_bit;
      if (is_oh) begin
         if (p_slot) out_bit = (par_en | frm_en) ? ov : pay_bit;
         else        out_bit = frm_en ? ov : pay_bit;
      end
   end
endmodule

// File: rtl/ds3c_framegen.sv
module ds3c_framegen #(
   parameter int SUB_N   = 7,
   parameter int BLK_N   = 8,
   parameter int BLK_LEN = 85,
   localparam int SF_W   = (SUB_N > 1) ? $clog2(SUB_N) : 1,
   localparam int BK_W   = (BLK_N > 1) ? $clog2(BLK_N) : 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic       pay_in,
   input  logic [1:0] rdi_mode,
   input  logic [3:0] alarm_in,
   input  logic [3:0] alarm_en,
   input  logic       par_en,
   input  logic       frm_en,
   input  logic       feac_bit,
   input  logic       cpar_bit,
   input  logic       febe_bit,
   input  logic       dlink_bit,
   output logic       ser_out,
   output logic       frame_start,
   output logic       oh_flag,
   output logic       pay_strobe
);
   import ds3c_pkg::*;

   // elaboration-time checks of the frame geometry
   generate
      if (SUB_N != 7) begin : g_bad_sub
         $error("ds3c_framegen: SUB_N must be 7");
      end
      if (BLK_N != 8) begin : g_bad_blk
         $error("ds3c_framegen: BLK_N must be 8");
      end
      if (BLK_LEN < 2) begin : g_bad_len
         $error("ds3c_framegen: BLK_LEN must be at least 2");
      end
   endgenerate

   logic [SF_W-1:0] sf;
   logic [BK_W-1:0] blk;
   logic            is_oh;
   logic            is_first;
   logic            is_last;
   logic            prev_par;
   logic            rdi_val;
   logic            alarm_hit;
   logic            nx_bit;
   rdi_sel_e        rdi_sel;

   ds3c_pos_ctr #(
      .SUB_N   (SUB_N),
      .BLK_N   (BLK_N),
      .BLK_LEN (BLK_LEN)
   ) pos_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (bit_en),
      .sf       (sf),
      .blk      (blk),
      .is_oh    (is_oh),
      .is_first (is_first),
      .is_last  (is_last)
   );

   ds3c_par_acc par_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (bit_en),
      .is_pay   (!is_oh),
      .pay_bit  (pay_in),
      .is_last  (is_last),
      .prev_par (prev_par)
   );

   // remote defect indication source
   assign rdi_sel   = rdi_sel_e'(rdi_mode);
   assign alarm_hit = |(alarm_in & alarm_en);

   always_comb begin
      case (rdi_sel)
         RDI_ONE:  rdi_val = 1'b1;
         RDI_ZERO: rdi_val = 1'b0;
         default:  rdi_val = !alarm_hit;
      endcase
   end

   ds3c_oh_sel #(
      .SF_W (SF_W),
      .BK_W (BK_W)
   ) sel_i (
      .sf        (sf),
      .blk       (blk),
      .is_oh     (is_oh),
      .pay_bit   (pay_in),
      .frm_en    (frm_en),
      .par_en    (par_en),
      .rdi_val   (rdi_val),
      .prev_par  (prev_par),
      .feac_bit  (feac_bit),
      .cpar_bit  (cpar_bit),
      .febe_bit  (febe_bit),
      .dlink_bit (dlink_bit),
      .out_bit   (nx_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ser_out     <= 1'b0;
         frame_start <= 1'b0;
         oh_flag     <= 1'b0;
         pay_strobe  <= 1'b0;
      end else begin
         frame_start <= bit_en & is_first;
         oh_flag     <= bit_en & is_oh;
         pay_strobe  <= bit_en & !is_oh;
         if (bit_en) ser_out <= nx_bit;
      end
   end
endmodule

// File: rtl/ds3c_framegen_chk.sv
module ds3c_framegen_chk #(
   parameter int FRAME_BITS = 4760
) (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic ser_out,
   input logic frame_start,
   input logic oh_flag,
   input logic pay_strobe
);
   logic [31:0] emit_cnt;
   logic        seen_start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         emit_cnt   <= '0;
         seen_start <= 1'b0;
      end else if (frame_start) begin
         emit_cnt   <= 32'd1;
         seen_start <= 1'b1;
      end else if (oh_flag | pay_strobe) begin
         emit_cnt <= emit_cnt + 32'd1;
      end
   end

   // R10
   start_is_oh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> oh_flag);

   // R10
   marker_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(oh_flag && pay_strobe));

   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> (!oh_flag && !pay_strobe && !frame_start && $stable(ser_out)));

   // R10
   frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && seen_start) |-> (emit_cnt == 32'(FRAME_BITS)));
endmodule

bind ds3c_framegen ds3c_framegen_chk #(
   .FRAME_BITS (SUB_N * BLK_N * BLK_LEN)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .bit_en      (bit_en),
   .ser_out     (ser_out),
   .frame_start (frame_start),
   .oh_flag     (oh_flag),
   .pay_strobe  (pay_strobe)
);

// File: tb/ds3c_framegen_tb_top.sv
module ds3c_framegen_tb_top;
   localparam int FRAME = 4760;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       pay_in = 1'b0;
   logic [1:0] rdi_mode = 2'b00;
   logic [3:0] alarm_in = 4'b0;
   logic [3:0] alarm_en = 4'b0;
   logic       par_en = 1'b0;
   logic       frm_en = 1'b1;
   logic       feac_bit = 1'b0;
   logic       cpar_bit = 1'b0;
   logic       febe_bit = 1'b0;
   logic       dlink_bit = 1'b0;
   logic       ser_out, frame_start, oh_flag, pay_strobe;

   always #4 clk = ~clk;

   ds3c_framegen dut_i (
      .clk (clk), .rst_n (rst_n), .bit_en (bit_en), .pay_in (pay_in),
      .rdi_mode (rdi_mode), .alarm_in (alarm_in), .alarm_en (alarm_en),
      .par_en (par_en), .frm_en (frm_en), .feac_bit (feac_bit),
      .cpar_bit (cpar_bit), .febe_bit (febe_bit), .dlink_bit (dlink_bit),
      .ser_out (ser_out), .frame_start (frame_start), .oh_flag (oh_flag),
      .pay_strobe (pay_strobe)
   );

   typedef struct {
      bit    ser;
      bit    fs;
      bit    oh;
      bit    ps;
      string tag;
   } exp_t;

   exp_t  sb_q[$];
   int    n_run = 0;
   int    n_fail = 0;
   int    pos = 0;
   bit    acc = 0;
   bit    prev = 0;
   bit    last_ser = 0;
   bit    mon_on = 0;

   // pending frame configuration, applied at the next driven bit
   bit [1:0] c_mode;
   bit [3:0] c_alm, c_aen;
   bit       c_par, c_frm;

   task automatic check(input string tag, input bit act, input bit exp_v, input string what);
      n_run++;
      if (act !== exp_v) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b at t=%0t", tag, what, act, exp_v, $time);
      end
   endtask

   task automatic drive(input bit en);
      exp_t e;
      int   b, blk, sf, k;
      bit   ov, rdi, is_p;
      string otag;
      @(negedge clk);
      rdi_mode  = c_mode;
      alarm_in  = c_alm;
      alarm_en  = c_aen;
      par_en    = c_par;
      frm_en    = c_frm;
      bit_en    = en;
      pay_in    = 1'($urandom);
      feac_bit  = 1'($urandom);
      cpar_bit  = 1'($urandom);
      febe_bit  = 1'($urandom);
      dlink_bit = 1'($urandom);
      if (!en) begin
         e.ser = last_ser; e.fs = 0; e.oh = 0; e.ps = 0; e.tag = "R12";
      end else begin
         b   = pos % 85;
         blk = (pos % 680) / 85;
         sf  = pos / 680;
         is_p = 0;
         if (c_mode == 2'b01)      rdi = 1;
         else if (c_mode == 2'b10) rdi = 0;
         else                      rdi = ((c_alm & c_aen) == 4'b0);
         if (b != 0) begin
            e.ser = pay_in; e.tag = "R1";
            acc ^= pay_in;
         end else begin
            if (blk == 0) begin
               if (sf < 2) begin
                  ov = rdi;
                  otag = (c_mode == 2'b01 || c_mode == 2'b10) ? "R4" : "R5";
               end else if (sf < 4) begin
                  ov = prev; otag = "R6"; is_p = 1;
               end else begin
                  ov = (sf == 5); otag = "R2";
               end
            end else if (blk % 2 == 1) begin
               ov = (blk == 1 || blk == 7); otag = "R3";
            end else begin
               k = blk / 2;
               if (sf == 0 && k == 3) begin ov = feac_bit; otag = "R7"; end
               else if (sf == 2)      begin ov = cpar_bit; otag = "R7"; end
               else if (sf == 3)      begin ov = febe_bit; otag = "R7"; end
               else if (sf == 4)      begin ov = dlink_bit; otag = "R7"; end
               else                   begin ov = 1; otag = "R8"; end
            end
            if (is_p) begin
               if (c_par || c_frm) begin e.ser = ov; e.tag = c_frm ? otag : "R9"; end
               else begin e.ser = pay_in; e.tag = "R9"; end
            end else if (!c_frm) begin
               e.ser = pay_in; e.tag = "R9";
            end else begin
               e.ser = ov; e.tag = otag;
            end
         end
         e.fs = (pos == 0);
         e.oh = (b == 0);
         e.ps = (b != 0);
         if (pos == FRAME - 1) begin
            prev = acc; acc = 0; pos = 0;
         end else begin
            pos++;
         end
         last_ser = e.ser;
      end
      sb_q.push_back(e);
   endtask

   task automatic run_frame(input bit [1:0] m, input bit [3:0] a, input bit [3:0] ae,
                            input bit p, input bit f);
      c_mode = m; c_alm = a; c_aen = ae; c_par = p; c_frm = f;
      for (int i = 0; i < FRAME; i++) begin
         if (i % 97 == 13) drive(1'b0);
         drive(1'b1);
      end
   endtask

   // monitor: pops one expected item per clock once stimulus starts
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #2;
         if (mon_on && sb_q.size() > 0) begin
            e = sb_q.pop_front();
            check(e.tag, ser_out, e.ser, "ser_out");
            check("R10", frame_start, e.fs, "frame_start");
            check("R10", oh_flag, e.oh, "oh_flag");
            check("R10", pay_strobe, e.ps, "pay_strobe");
         end
      end
   end

   initial begin
      #(200000 * 8);
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      c_mode = 0; c_alm = 0; c_aen = 0; c_par = 0; c_frm = 1;
      repeat (4) @(negedge clk);
      // R11: reset state
      check("R11", ser_out, 1'b0, "ser_out");
      check("R11", frame_start, 1'b0, "frame_start");
      check("R11", oh_flag, 1'b0, "oh_flag");
      check("R11", pay_strobe, 1'b0, "pay_strobe");
      rst_n = 1'b1;
      mon_on = 1;
      // R11: first enabled bit is frame position 0 (frame_start checked by monitor)
      run_frame(2'b00, 4'b0001, 4'b1111, 1'b0, 1'b1); // R5 LOS active+enabled, R6 first P=0
      run_frame(2'b00, 4'b1000, 4'b0001, 1'b0, 1'b1); // R5 AIS masked
      run_frame(2'b00, 4'b0100, 4'b0100, 1'b0, 1'b1); // R5 LOF
      run_frame(2'b10, 4'b0000, 4'b0000, 1'b0, 1'b1); // R4 forced 0
      run_frame(2'b01, 4'b1111, 4'b1111, 1'b0, 1'b1); // R4 forced 1
      run_frame(2'b00, 4'b0000, 4'b0000, 1'b1, 1'b0); // R9 parity only
      run_frame(2'b00, 4'b0000, 4'b0000, 1'b0, 1'b0); // R9 all pass
      run_frame(2'b11, 4'b0010, 4'b0010, 1'b0, 1'b1); // R4 alt auto, R5 SEF
      drive(1'b0);                                    // R12 trailing idle
      @(negedge clk);
      bit_en = 1'b0;
      repeat (3) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule